// File: doc/BRIEF.md
# Serial-In Shift Register with Parallel Storage Latch

This block is a serial-to-parallel stage. Bits clocked in on a serial input fill a shift register of `WIDTH` bits (16 by default). A store strobe then copies the whole register into a storage latch, and the latch alone drives the parallel output bus. For readback there is a read mode. In read mode the serial line becomes an output that shows the register's top bit. In the same mode the register can be reloaded from the latch and shifted out bit by bit. An active-low clear empties the latch. A chip select gates every strobe and the serial driver.

Every control input arrives asynchronously and passes through a `SYNC_STAGES`-deep synchronizer onto the system clock. The two strobes act on their rising edge only. One pin does two jobs, selected by the read/write level. With read/write low it is the store strobe. With read/write high it is the level that chooses between reload and shift. The bidirectional serial line is exposed as three signals: a data input, a data output and an output enable, so a pad cell or the next level up can join them.

A control state machine holds the decoded operating state. The state can be `ST_OFF` (chip deselected), `ST_WRITE` (serial input, store allowed), `ST_RELOAD` (read, shift strobe loads the latch into the register) or `ST_SHIFT` (read, shift strobe shifts). The state is recomputed from the synchronized levels on every clock. Reset enters `ST_OFF`. From any state, chip select high goes to `ST_OFF`. Chip select low with read/write low goes to `ST_WRITE`. Chip select low with read/write high goes to `ST_RELOAD` when the mode level is high and to `ST_SHIFT` when it is low. A strobe whose rising edge is sampled at clock edge k changes the register or latch at edge k+3. A change of chip select or read/write reaches the output enable at edge k+2. A clear level reaches the latch at edge k+2.

Top module: `serial_latch_reg`

## Requirements
- R1: A synchronous reset (`rst` high) clears both the shift register and the storage latch to all zeros, so `par_o` reads 0 and a later reload shows 0 on `sdo_o`.
- R2: In write mode (`cs_n_i` low, `rw_i` low), each rising edge of `shift_stb_i` moves the register one place toward bit `WIDTH-1` and takes `sdi_i` into bit 0. Shifting the pairs 0 then 1 eight times and then storing gives `par_o` = 0x5555.
- R3: `par_o` changes only on a rising edge of `mode_stb_i` in write mode, on clear or on reset, and a store copies the shift register's current value. Shift strobes alone leave `par_o` unchanged.
- R4: After the 0x5555 store, one more shift of a 0 followed by a store gives `par_o` = 0xAAAA.
- R5: `sdo_oe_o` is 1 exactly when `cs_n_i` is low and `rw_i` is high, and `sdo_o` always carries bit `WIDTH-1` of the shift register.
- R6: In read mode with `mode_stb_i` held high, a rising edge of `shift_stb_i` loads the storage latch into the shift register instead of shifting.
- R7: In read mode with `mode_stb_i` low, a rising edge of `shift_stb_i` shifts the register toward bit `WIDTH-1` and fills bit 0 with 0. After a 0x5555 reload, `sdo_o` reads 0 and then 1 after one shift.
- R8: While `clr_n_i` is low the latch is held at zero and store strobes are ignored. After release the latch stays zero until the next store.
- R9: While `cs_n_i` is high, `sdo_oe_o` is 0 and shift and store strobes change neither the shift register nor the latch.
- R10: Each strobe pulse causes at most one action: a strobe held high acts only once. A rising edge on `mode_stb_i` in read mode never stores.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n_i | input | 1 | Chip select, active low |
| rw_i | input | 1 | 1 = read mode, 0 = write mode |
| shift_stb_i | input | 1 | Shift strobe, acts on rising edge |
| mode_stb_i | input | 1 | Store strobe in write mode; reload/shift select level in read mode |
| clr_n_i | input | 1 | Latch clear, active low, level sensitive |
| sdi_i | input | 1 | Serial data in (write mode) |
| sdo_o | output | 1 | Serial data out, top bit of the shift register |
| sdo_oe_o | output | 1 | Drive enable for the serial line |
| par_o | output | WIDTH | Parallel output, storage latch contents |

## Verification
The alternating 0/1 serial stream tells a correct shift direction and bit 0 entry point from a reversed or off-by-one register, because it must give 0x5555 and, after one extra zero, 0xAAAA. Reloading 0x5555 and shifting in read mode shows whether reload and shift were swapped, because the serial output must follow 0, 1, 0. A later store of the read-shifted value shows what fill bit the read shift used. A strobe held high for many cycles, a mode edge in read mode, stores while the clear is low and strobes while deselected are each followed by a store or a parallel read. That tells an ignored stimulus apart from one that leaked into the register or the latch.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    // Decoded operating state of the control machine
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_WRITE  = 2'd1,
        ST_RELOAD = 2'd2,
        ST_SHIFT  = 2'd3
    } ssr_state_e;

    // One-cycle actions issued by control to the datapath
    typedef struct packed {
        logic shift;
        logic load;
        logic store;
    } ssr_act_t;

    // Bit positions inside the synchronizer bus
    localparam int unsigned SYN_CS_N  = 0;
    localparam int unsigned SYN_RW    = 1;
    localparam int unsigned SYN_SHIFT = 2;
    localparam int unsigned SYN_MODE  = 3;
    localparam int unsigned SYN_CLR_N = 4;
    localparam int unsigned SYN_SDI   = 5;
    localparam int unsigned SYN_BITS  = 6;

endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
    parameter int unsigned          W       = 1,
    parameter int unsigned          STAGES  = 2,
    parameter logic [W-1:0]         RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/ssr_edge.sv
module ssr_edge #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);

    logic [W-1:0] prev_q;
    logic [W-1:0] rise_q;

    // Registered rise: aligned with the control state register
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            rise_q <= '0;
        end else begin
            prev_q <= lvl_i;
            rise_q <= lvl_i & ~prev_q;
        end
    end

    assign rise_o = rise_q;

endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
    import ssr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n_s,
    input  logic       rw_s,
    input  logic       mode_s,
    input  logic       sdi_s,
    input  logic       shift_rise,
    input  logic       store_rise,
    output ssr_state_e state_o,
    output ssr_act_t   act_o,
    output logic       fill_bit_o,
    output logic       oe_o
);

    ssr_state_e state_q;
    ssr_state_e state_d;
    logic       sdi_q;

    // Next-state decode from synchronized levels
    always_comb begin
        if (cs_n_s) begin
            state_d = ST_OFF;
        end else if (!rw_s) begin
            state_d = ST_WRITE;
        end else if (mode_s) begin
            state_d = ST_RELOAD;
        end else begin
            state_d = ST_SHIFT;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            sdi_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sdi_q   <= sdi_s;
        end
    end

    // Outputs per state
    always_comb begin
        act_o      = '0;
        fill_bit_o = 1'b0;
        oe_o       = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                act_o = '0;
            end
            ST_WRITE: begin
                act_o.shift = shift_rise;
                act_o.store = store_rise;
                fill_bit_o  = sdi_q;
            end
            ST_RELOAD: begin
                act_o.load = shift_rise;
                oe_o       = 1'b1;
            end
            ST_SHIFT: begin
                act_o.shift = shift_rise;
                oe_o        = 1'b1;
            end
            default: begin
                act_o = '0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/ssr_datapath.sv
module ssr_datapath
    import ssr_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ssr_act_t         act_i,
    input  logic             fill_bit_i,
    input  logic             clr_n_s,
    output logic [WIDTH-1:0] shift_o,
    output logic [WIDTH-1:0] latch_o
);

    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] shift_q;
    logic [WIDTH-1:0] latch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
        end else if (act_i.load) begin
            shift_q <= latch_q;
        end else if (act_i.shift) begin
            shift_q <= {shift_q[MSB-1:0], fill_bit_i};
        end
    end

    // Clear wins over store; store takes the pre-shift value
    always_ff @(posedge clk) begin
        if (rst || !clr_n_s) begin
            latch_q <= '0;
        end else if (act_i.store) begin
            latch_q <= shift_q;
        end
    end

    assign shift_o = shift_q;
    assign latch_o = latch_q;

endmodule

// File: rtl/serial_latch_reg.sv
module serial_latch_reg
    import ssr_pkg::*;
#(
    parameter int unsigned WIDTH       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n_i,
    input  logic             rw_i,
    input  logic             shift_stb_i,
    input  logic             mode_stb_i,
    input  logic             clr_n_i,
    input  logic             sdi_i,
    output logic             sdo_o,
    output logic             sdo_oe_o,
    output logic [WIDTH-1:0] par_o
);

    localparam logic [SYN_BITS-1:0] SYN_RST =
        SYN_BITS'((1 << SYN_CS_N) | (1 << SYN_CLR_N));

    logic [SYN_BITS-1:0] raw_bus;
    logic [SYN_BITS-1:0] syn_bus;
    logic [1:0]          rise_bus;
    ssr_state_e          state;
    ssr_act_t            act;
    logic                fill_bit;
    logic                oe;
    logic [WIDTH-1:0]    shift_q;
    logic [WIDTH-1:0]    latch_q;
    logic                clr_n_s;

    always_comb begin
        raw_bus            = '0;
        raw_bus[SYN_CS_N]  = cs_n_i;
        raw_bus[SYN_RW]    = rw_i;
        raw_bus[SYN_SHIFT] = shift_stb_i;
        raw_bus[SYN_MODE]  = mode_stb_i;
        raw_bus[SYN_CLR_N] = clr_n_i;
        raw_bus[SYN_SDI]   = sdi_i;
    end

    ssr_sync #(
        .W      (SYN_BITS),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYN_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_bus),
        .q_o (syn_bus)
    );

    ssr_edge #(
        .W(2)
    ) u_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl_i ({syn_bus[SYN_MODE], syn_bus[SYN_SHIFT]}),
        .rise_o(rise_bus)
    );

    ssr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs_n_s    (syn_bus[SYN_CS_N]),
        .rw_s      (syn_bus[SYN_RW]),
        .mode_s    (syn_bus[SYN_MODE]),
        .sdi_s     (syn_bus[SYN_SDI]),
        .shift_rise(rise_bus[0]),
        .store_rise(rise_bus[1]),
        .state_o   (state),
        .act_o     (act),
        .fill_bit_o(fill_bit),
        .oe_o      (oe)
    );

    assign clr_n_s = syn_bus[SYN_CLR_N];

    ssr_datapath #(
        .WIDTH(WIDTH)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .act_i     (act),
        .fill_bit_i(fill_bit),
        .clr_n_s   (clr_n_s),
        .shift_o   (shift_q),
        .latch_o   (latch_q)
    );

    assign sdo_o    = shift_q[WIDTH-1];
    assign sdo_oe_o = oe;
    assign par_o    = latch_q;

endmodule

// File: rtl/ssr_checker.sv
module ssr_checker
    import ssr_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input ssr_state_e       state,
    input ssr_act_t         act,
    input logic             clr_n_s,
    input logic [WIDTH-1:0] shift_q,
    input logic [WIDTH-1:0] latch_q,
    input logic             sdo_oe_o
);

    // R2 / R7: a shift moves every bit up by one place
    assert_shift_moves_R2: assert property (@(posedge clk) disable iff (rst)
        act.shift |=> shift_q[WIDTH-1:1] == $past(shift_q[WIDTH-2:0]));

    // R6: a reload copies the latch into the register
    assert_reload_copies_R6: assert property (@(posedge clk) disable iff (rst)
        act.load |=> shift_q == $past(latch_q));

    // R3: the latch moves only on store or clear
    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!act.store && clr_n_s) |=> $stable(latch_q));

    // R8: clear low empties the latch
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !clr_n_s |=> latch_q == '0);

    // R9: deselected, nothing moves
    assert_off_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF && clr_n_s) |=> ($stable(shift_q) && $stable(latch_q)));

    // R10: one action per strobe, never shift and reload together
    assert_single_action_R10: assert property (@(posedge clk) disable iff (rst)
        (act.shift || act.load) |=> !(act.shift || act.load));

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({act.shift, act.load}));

    // R5 / R10: a store only ever happens while the serial driver is off
    assert_store_in_write_R5: assert property (@(posedge clk) disable iff (rst)
        act.store |-> !sdo_oe_o);

endmodule

bind serial_latch_reg ssr_checker #(
    .WIDTH(WIDTH)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .state   (state),
    .act     (act),
    .clr_n_s (clr_n_s),
    .shift_q (shift_q),
    .latch_q (latch_q),
    .sdo_oe_o(sdo_oe_o)
);

// File: tb/serial_latch_reg_tb.sv
module serial_latch_reg_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n_i = 1'b1;
    logic         rw_i = 1'b0;
    logic         shift_stb_i = 1'b0;
    logic         mode_stb_i = 1'b0;
    logic         clr_n_i = 1'b1;
    logic         sdi_i = 1'b0;
    logic         sdo_o;
    logic         sdo_oe_o;
    logic [W-1:0] par_o;

    always #2 clk = ~clk;

    serial_latch_reg #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .cs_n_i     (cs_n_i),
        .rw_i       (rw_i),
        .shift_stb_i(shift_stb_i),
        .mode_stb_i (mode_stb_i),
        .clr_n_i    (clr_n_i),
        .sdi_i      (sdi_i),
        .sdo_o      (sdo_o),
        .sdo_oe_o   (sdo_oe_o),
        .par_o      (par_o)
    );

    // Scoreboard item: kind 0 = par_o, 1 = sdo_o, 2 = sdo_oe_o
    typedef struct {
        int           kind;
        logic [W-1:0] val;
        string        req;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Monitor: compares queued expectations against the ports
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            logic [W-1:0] got;
            it = sb_q.pop_front();
            case (it.kind)
                0:       got = par_o;
                1:       got = W'(sdo_o);
                default: got = W'(sdo_oe_o);
            endcase
            n_checks++;
            if (got !== it.val) begin
                n_fails++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.val);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_item(input int kind, input logic [W-1:0] val, input string req);
        sb_item_t it;
        it.kind = kind;
        it.val  = val;
        it.req  = req;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
        cyc(1);
    endtask

    task automatic pulse_shift(input logic bitv);
        sdi_i = bitv;
        cyc(1);
        shift_stb_i = 1'b1;
        cyc(3);
        shift_stb_i = 1'b0;
        cyc(3);
    endtask

    task automatic pulse_store();
        mode_stb_i = 1'b1;
        cyc(3);
        mode_stb_i = 1'b0;
        cyc(5);
    endtask

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(4);
        // R1: reset state
        expect_item(0, 16'h0000, "R1 latch after reset");
        expect_item(2, 16'h0000, "R5 oe off while deselected");

        cs_n_i = 1'b0;
        rw_i   = 1'b0;
        cyc(5);
        expect_item(2, 16'h0000, "R5 oe off in write mode");

        // R2: alternating stream
        for (int i = 0; i < 8; i++) begin
            pulse_shift(1'b0);
            pulse_shift(1'b1);
        end
        expect_item(0, 16'h0000, "R3 shifts alone leave outputs");
        pulse_store();
        expect_item(0, 16'h5555, "R2 store after 0,1 x8");

        // R4
        pulse_shift(1'b0);
        expect_item(0, 16'h5555, "R3 shift without store");
        pulse_store();
        expect_item(0, 16'hAAAA, "R4 extra zero then store");

        // back to 0x5555 in latch, register 0xAAAA
        for (int i = 0; i < 8; i++) begin
            pulse_shift(1'b0);
            pulse_shift(1'b1);
        end
        pulse_store();
        pulse_shift(1'b0);
        expect_item(0, 16'h5555, "R3 latch holds 0x5555");

        // Read mode
        rw_i = 1'b1;
        cyc(5);
        expect_item(2, 16'h0001, "R5 oe on in read mode");
        expect_item(1, 16'h0001, "R5 sdo shows bit15 of 0xAAAA");

        // R6 reload
        mode_stb_i = 1'b1;
        cyc(5);
        expect_item(0, 16'h5555, "R10 mode edge in read does not store");
        pulse_shift(1'b0);
        expect_item(1, 16'h0000, "R6 reload gives bit15 0");
        mode_stb_i = 1'b0;
        cyc(5);

        // R7 shifts
        pulse_shift(1'b1);
        expect_item(1, 16'h0001, "R7 sdo after one shift");
        pulse_shift(1'b1);
        expect_item(1, 16'h0000, "R7 sdo after two shifts");
        // register now 0x5554; mode edge in read mode
        mode_stb_i = 1'b1;
        cyc(3);
        mode_stb_i = 1'b0;
        cyc(5);
        expect_item(0, 16'h5555, "R10 read mode edge ignored");

        rw_i = 1'b0;
        cyc(5);
        pulse_store();
        expect_item(0, 16'h5554, "R7 read shift fills zero");

        // R10 held strobe
        sdi_i = 1'b1;
        cyc(1);
        shift_stb_i = 1'b1;
        cyc(20);
        shift_stb_i = 1'b0;
        cyc(4);
        pulse_store();
        expect_item(0, 16'hAAA9, "R10 held strobe shifts once");

        // R8 clear
        clr_n_i = 1'b0;
        cyc(4);
        expect_item(0, 16'h0000, "R8 clear low");
        pulse_store();
        expect_item(0, 16'h0000, "R8 store ignored during clear");
        clr_n_i = 1'b1;
        cyc(4);
        expect_item(0, 16'h0000, "R8 zero after release");
        pulse_store();
        expect_item(0, 16'hAAA9, "R8 store after release");

        // R9 deselect
        cs_n_i = 1'b1;
        cyc(5);
        expect_item(2, 16'h0000, "R9 oe off deselected");
        pulse_shift(1'b1);
        pulse_store();
        expect_item(0, 16'hAAA9, "R9 store ignored deselected");
        rw_i = 1'b1;
        cyc(5);
        expect_item(2, 16'h0000, "R9 oe off deselected read");
        rw_i = 1'b0;
        cs_n_i = 1'b0;
        cyc(5);
        pulse_store();
        expect_item(0, 16'hAAA9, "R9 register untouched while deselected");

        // R1 mid-run reset
        rst = 1'b1;
        cyc(3);
        rst = 1'b0;
        cyc(4);
        expect_item(0, 16'h0000, "R1 latch after second reset");
        rw_i = 1'b1;
        mode_stb_i = 1'b1;
        cyc(5);
        pulse_shift(1'b0);
        expect_item(1, 16'h0000, "R1 reload of cleared latch");
        mode_stb_i = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule